// File: doc/BRIEF.md
# Serial Bus Clock-Low Timeout Monitor

This block watches a two-wire serial bus (clock line and data line, both already synchronized to the system clock). It measures, in system clock cycles, how long the clock line stays low. When the low time reaches a threshold, it sends a one-cycle reset pulse to the slave-side serial logic. It then drops its ready flag and keeps it low until a fresh Start condition appears on the bus. A Start is the data line falling while the clock line is high.

The timeout window is set by two parameters. `LOW_MIN_CYC` is the low time that must never cause a reset, and `LOW_MAX_CYC` is the low time that must always cause one. The block uses a single threshold at the midpoint of the two. Both lines first pass through a stable-count glitch filter of depth `FILT_CYC`. Bus conditions and the low-time measurement are taken only from the filtered lines.

There is no data stream at the edge of this block. Its pins are plain control and status levels, so no valid/ready handshake applies.

Top module: `bus_timeout_monitor`

## Requirements
- R1: While reset is active and right after it is released, `iface_rst_o` is 0 and `ready_o` is 1.
- R2: The threshold is THR = (LOW_MIN_CYC+LOW_MAX_CYC)/2. A clock-low period of fewer than THR consecutive sampled cycles produces no pulse on `iface_rst_o`. This includes every period shorter than LOW_MIN_CYC.
- R3: A clock-low period of THR or more sampled cycles produces a pulse on `iface_rst_o` that is exactly one cycle wide. This includes every period longer than LOW_MAX_CYC.
- R4: The low-time counter saturates at THR. A single stuck-low period of any length therefore yields exactly one pulse.
- R5: `ready_o` falls in the cycle after the pulse. It then stays 0 through Stop conditions (data rising while the clock is high) and through clock activity that carries no Start.
- R6: A Start condition on the filtered lines returns `ready_o` to 1.
- R7: On either line, a level that lasts fewer than FILT_CYC consecutive cycles is suppressed. An SDA dip this short does not count as a Start, and a clock high spike this short does not restart the low-time measurement.
- R8: A level held for FILT_CYC or more cycles passes the filter. A clock-high period of at least FILT_CYC cycles clears the low-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| iface_rst_o | output | 1 | One-cycle reset pulse to the serial slave logic |
| ready_o | output | 1 | 1 when bus traffic is accepted; 0 from a timeout until the next Start |

## Verification
The assertions assume `scl_i` and `sda_i` are already synchronous to `clk`. The filter-change property relates the filtered level to the raw level sampled one cycle earlier, so it would be wrong for an asynchronous input. The properties also assume the threshold is at least 2.

The stimulus keeps within these assumptions. It changes the lines only on the falling edge of the clock and holds each level for a whole number of cycles. A Start or Stop is formed only while the clock line is steady high.

The low-time sweep covers every length from 1 to 60 cycles around a threshold of 40. The glitch cases use widths exactly one below and exactly equal to the filter depth.

// File: rtl/bto_pkg.sv
package bto_pkg;

  // Index of each line in the raw/filtered line vectors
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

  // Bus events decoded from the filtered lines
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } bus_evt_t;

endpackage

// File: rtl/bto_glitch_filter.sv
// Stable-count filter: the output follows the input only after the input
// has differed from the output for FILT_CYC consecutive samples.
module bto_glitch_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= 1'b1;
      cnt <= '0;
    end else if (din == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= din;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign dout = q;
endmodule

// File: rtl/bto_cond_detect.sv
// Decodes Start/Stop and clock edges from the filtered lines.
module bto_cond_detect
  import bto_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl,
  input  logic     sda,
  output bus_evt_t evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_comb begin
    evt.start    = scl_d & scl & sda_d & ~sda;
    evt.stop     = scl_d & scl & ~sda_d & sda;
    evt.scl_rise = ~scl_d & scl;
    evt.scl_fall = scl_d & ~scl;
  end
endmodule

// File: rtl/bto_low_timer.sv
// Counts cycles of filtered SCL low, saturating at THRESH; emits one
// registered pulse on the cycle the count reaches THRESH.
module bto_low_timer #(
  parameter int THRESH = 40,
  parameter int CNT_W  = $clog2(THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  output logic             expire,
  output logic [CNT_W-1:0] low_cnt
);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(THRESH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      expire  <= 1'b0;
    end else begin
      expire <= ~scl & (low_cnt == PRE);
      if (scl)
        low_cnt <= '0;
      else if (low_cnt != TOP)
        low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
  import bto_pkg::*;
#(
  parameter int LOW_MIN_CYC = 3_125_000,
  parameter int LOW_MAX_CYC = 4_375_000,
  parameter int FILT_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic iface_rst_o,
  output logic ready_o
);
  localparam int THRESH_CYC = (LOW_MIN_CYC + LOW_MAX_CYC) / 2;
  localparam int CNT_W      = $clog2(THRESH_CYC + 1);

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] flt_lines;
  logic                 scl_flt;
  logic                 sda_flt;
  bus_evt_t             evt;
  logic                 start_det;
  logic                 expire;
  logic [CNT_W-1:0]     low_cnt;
  logic                 ignore_q;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
    bto_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[LINE_SCL];
  assign sda_flt = flt_lines[LINE_SDA];

  bto_cond_detect u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .scl  (scl_flt),
    .sda  (sda_flt),
    .evt  (evt)
  );

  assign start_det = evt.start;

  bto_low_timer #(.THRESH(THRESH_CYC), .CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl    (scl_flt),
    .expire (expire),
    .low_cnt(low_cnt)
  );

  // Ignore flag: set by a timeout, cleared only by a fresh Start
  always_ff @(posedge clk) begin
    if (!rst_n)         ignore_q <= 1'b0;
    else if (expire)    ignore_q <= 1'b1;
    else if (start_det) ignore_q <= 1'b0;
  end

  assign iface_rst_o = expire;
  assign ready_o     = ~ignore_q;
endmodule

// File: rtl/bus_timeout_monitor_chk.sv
module bus_timeout_monitor_chk #(
  parameter int THRESH = 40,
  parameter int CNT_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_raw,
  input logic             scl_f,
  input logic             start,
  input logic [CNT_W-1:0] low_cnt,
  input logic             iface_rst,
  input logic             ready
);
  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |=> !iface_rst);

  // R2
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |-> ($past(low_cnt) == CNT_W'(THRESH - 1)));

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CNT_W'(THRESH));

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |=> !ready);

  // R5
  ready_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(iface_rst));

  // R6
  ready_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(start));

  // R7
  scl_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> ($past(scl_raw) == scl_f));

  // R8
  low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_f |=> (low_cnt == '0));
endmodule

bind bus_timeout_monitor bus_timeout_monitor_chk #(
  .THRESH(THRESH_CYC),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_raw  (scl_i),
  .scl_f    (scl_flt),
  .start    (start_det),
  .low_cnt  (low_cnt),
  .iface_rst(iface_rst_o),
  .ready    (ready_o)
);

// File: tb/test_bus_timeout_monitor.sv
module test_bus_timeout_monitor;
  localparam int MIN  = 30;
  localparam int MAX  = 50;
  localparam int FILT = 4;
  localparam int THR  = (MIN + MAX) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic iface_rst;
  logic ready;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int run = 0;
  int max_run = 0;

  always #4 clk = ~clk;

  bus_timeout_monitor #(
    .LOW_MIN_CYC(MIN),
    .LOW_MAX_CYC(MAX),
    .FILT_CYC   (FILT)
  ) i_bus_timeout_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda),
    .iface_rst_o(iface_rst),
    .ready_o    (ready)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (iface_rst) begin
        pulses++;
        run++;
        if (run > max_run) max_run = run;
      end else begin
        run = 0;
      end
    end
  end

  task automatic drive(input logic c, input logic d, input int n);
    scl = c;
    sda = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: outputs while in reset
    chk("R1 rst in reset", int'(iface_rst), 0);
    chk("R1 ready in reset", int'(ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rst after reset", int'(iface_rst), 0);
    chk("R1 ready after reset", int'(ready), 1);

    // R2/R3 sweep of low time around the threshold
    for (int len = 1; len <= 60; len++) begin
      drive(1'b1, 1'b1, 10);
      drive(1'b1, 1'b0, 10);
      chk("R6 ready after start", int'(ready), 1);
      pulses = 0;
      max_run = 0;
      drive(1'b0, 1'b0, len);
      drive(1'b1, 1'b0, 10);
      drive(1'b1, 1'b1, 10);
      if (len >= THR) begin
        chk("R3 pulse count", pulses, 1);
        chk("R3 pulse width", max_run, 1);
        chk("R5 ready after timeout and stop", int'(ready), 0);
      end else begin
        chk("R2 no pulse", pulses, 0);
        chk("R2 ready kept", int'(ready), 1);
      end
    end

    // R4: one long stuck-low period gives one pulse
    drive(1'b1, 1'b0, 10);
    pulses = 0;
    max_run = 0;
    drive(1'b0, 1'b0, 300);
    drive(1'b1, 1'b0, 10);
    chk("R4 single pulse", pulses, 1);
    chk("R4 pulse width", max_run, 1);
    drive(1'b1, 1'b1, 10);
    // R5: clock activity without a Start keeps ready low
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, 1'b1, 6);
      drive(1'b1, 1'b1, 6);
    end
    chk("R5 ready held low", int'(ready), 0);
    chk("R5 no extra pulse", pulses, 1);

    // R7: SDA dip of FILT-1 cycles is not a Start
    drive(1'b1, 1'b0, FILT - 1);
    drive(1'b1, 1'b1, 10);
    chk("R7 short sda dip ignored", int'(ready), 0);
    // R8/R6: SDA low for exactly FILT cycles is a Start
    drive(1'b1, 1'b0, FILT);
    drive(1'b1, 1'b1, 10);
    chk("R6 start of filter depth", int'(ready), 1);

    // R7: SCL high spike of FILT-1 cycles does not restart the count
    drive(1'b1, 1'b0, 10);
    pulses = 0;
    drive(1'b0, 1'b0, 25);
    drive(1'b1, 1'b0, FILT - 1);
    drive(1'b0, 1'b0, 25);
    drive(1'b1, 1'b0, 10);
    chk("R7 scl spike suppressed", pulses, 1);
    drive(1'b1, 1'b1, 10);
    drive(1'b1, 1'b0, 10);
    chk("R6 ready after restart", int'(ready), 1);

    // R8: SCL high of FILT cycles clears the count
    pulses = 0;
    drive(1'b0, 1'b0, 25);
    drive(1'b1, 1'b0, FILT);
    drive(1'b0, 1'b0, 25);
    drive(1'b1, 1'b0, 10);
    chk("R8 high clears count", pulses, 0);
    chk("R8 ready kept", int'(ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule